// File: doc/BRIEF.md
# Burst-of-Two Split-Bus SRAM Controller

This block sits on the host side of a synchronous SRAM that has one bus for write data, a separate bus for read data, and a fixed burst length of two words. A user asks for a whole two-word burst in a single valid/ready handshake. A write request carries both words and a byte-enable mask for each word. A read request returns both words together with a one-cycle valid pulse. The memory stores each burst as one wide entry, and the two words always keep their order.

The double-edge memory interface runs on an internal clock at twice the memory rate. A phase bit, `memClkK`, splits that clock into alternating slots. In a slot where `memClkK` is 1, the memory's primary clock rises. In the next slot the inverted clock rises. Commands go out only in primary slots. Write data follows the command in split form. Read words are sampled a configurable number of slots after the command. `READ_LAT` must be even and at least 2.

Top module: `sio_burst2_ctrl`

## Requirements
- R1: During reset and afterwards, `memLoadN` stays high in every slot that issues no command, and it is never low in a slot where `memClkK` is 0. Right after reset `memBwN` is all ones and `rspValid` is 0.
- R2: A read accepted at clock edge n drives the following in slot n, which is a `memClkK`=1 slot: `memLoadN`=0, `memRw`=1, and `memAddr` equal to the requested address.
- R3: A write accepted at edge n drives the following in slot n: `memLoadN`=0, `memRw`=0, and the requested address.
- R4: For a write accepted at edge n, slot n+2 (`memClkK`=1) carries word 0 on `memD` with `memBwN` = ~`reqMask0`. Slot n+3 carries word 1 with `memBwN` = ~`reqMask1`. In every other slot `memBwN` is all ones.
- R5: Byte lane b is bits [8b+7:8b]. It is written only when user mask bit b is 1, which shows as `memBwN` bit b = 0 (active low). A word whose mask is all zero leaves its stored word unchanged.
- R6: `reqReady` is 1 only in slots where `memClkK` is 0. After a write is accepted at edge n, `reqReady` stays 0 through slot n+2, so no command can issue before the second write word has been driven.
- R7: For a read accepted at edge n, word 0 is taken from `memQ` at the end of slot n+READ_LAT and word 1 at the end of slot n+READ_LAT+1. `rspValid` is high for exactly slot n+READ_LAT+2, with both words on `rspData0` and `rspData1`. Values on `memQ` in other slots have no effect.
- R8: Reads can be accepted every second slot. Their responses come back in request order, with the two words of each burst in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal clock at twice the memory rate |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken at the next edge |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqAddr | input | ADDR_W | Burst address |
| reqWdata0 | input | DATA_W | First write word |
| reqWdata1 | input | DATA_W | Second write word |
| reqMask0 | input | DATA_W/8 | Byte enables for word 0, active high |
| reqMask1 | input | DATA_W/8 | Byte enables for word 1, active high |
| rspValid | output | 1 | One-cycle read response pulse |
| rspData0 | output | DATA_W | First read word |
| rspData1 | output | DATA_W | Second read word |
| memClkK | output | 1 | Phase: 1 in primary-clock slots |
| memLoadN | output | 1 | Command load, active low |
| memRw | output | 1 | 1 = read, 0 = write |
| memAddr | output | ADDR_W | Memory address |
| memD | output | DATA_W | Write data bus |
| memBwN | output | DATA_W/8 | Byte write enables, active low |
| memQ | input | DATA_W | Read data bus |

## Verification
The assertions rely on two things about the user port. Request fields must be held stable while `reqValid` waits for `reqReady`. The memory must present read words on `memQ` in the slots fixed by `READ_LAT`. The bench meets both conditions. It changes request fields only at falling edges, before the handshake edge. Its behavioural memory places read words at exactly the required slots. Outside those slots it leaves `memQ` floating, or, in one scenario, fills it with a noise pattern to show that those values are ignored.

// File: rtl/sio_b2_pkg.sv
package sio_b2_pkg;
  typedef struct packed {
    logic launch;    // command goes out in the next slot
    logic isWrite;   // command type for launch
    logic drvWord0;  // drive first write word next slot
    logic drvWord1;  // drive second write word next slot
    logic cap0;      // sample first read word now
    logic cap1;      // sample second read word now
  } ctlStrobe_t;
endpackage

// File: rtl/sio_b2_ctrl.sv
module sio_b2_ctrl
  import sio_b2_pkg::*;
#(
  parameter int READ_LAT = 4
) (
  input  logic       clk2x,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       kPhase,
  output ctlStrobe_t strobe
);
  localparam int RD_LEN = READ_LAT + 2;

  logic [2:0]        wrShift;
  logic [RD_LEN-1:0] rdShift;
  logic              accept;

  // a command may only launch into a primary slot, and never while a
  // write's data slots are still outstanding
  assign reqReady = !kPhase && (wrShift == 3'b000);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      kPhase  <= 1'b0;
      wrShift <= '0;
      rdShift <= '0;
    end else begin
      kPhase  <= !kPhase;
      wrShift <= {wrShift[1:0], accept && reqWrite};
      rdShift <= {rdShift[RD_LEN-2:0], accept && !reqWrite};
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.launch   = accept;
    strobe.isWrite  = reqWrite;
    strobe.drvWord0 = wrShift[1];
    strobe.drvWord1 = wrShift[2];
    strobe.cap0     = rdShift[READ_LAT];
    strobe.cap1     = rdShift[READ_LAT+1];
  end
endmodule

// File: rtl/sio_b2_dp.sv
module sio_b2_dp
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk2x,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata0,
  input  logic [DATA_W-1:0]   reqWdata1,
  input  logic [DATA_W/8-1:0] reqMask0,
  input  logic [DATA_W/8-1:0] reqMask1,
  input  logic [DATA_W-1:0]   memQ,
  output logic                memLoadN,
  output logic                memRw,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memD,
  output logic [DATA_W/8-1:0] memBwN,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData0,
  output logic [DATA_W-1:0]   rspData1
);
  localparam int NBYTE = DATA_W / 8;

  logic [DATA_W-1:0] holdW0, holdW1;
  logic [NBYTE-1:0]  holdM0, holdM1;

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      memLoadN <= 1'b1;
      memRw    <= 1'b1;
      memAddr  <= '0;
      holdW0   <= '0;
      holdW1   <= '0;
      holdM0   <= '0;
      holdM1   <= '0;
    end else begin
      memLoadN <= !strobe.launch;
      if (strobe.launch) begin
        memRw   <= !strobe.isWrite;
        memAddr <= reqAddr;
        if (strobe.isWrite) begin
          holdW0 <= reqWdata0;
          holdW1 <= reqWdata1;
          holdM0 <= reqMask0;
          holdM1 <= reqMask1;
        end
      end
    end
  end

  // per-byte write lanes
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    always_ff @(posedge clk2x or negedge rstN) begin
      if (!rstN) begin
        memD[8*b +: 8] <= '0;
        memBwN[b]      <= 1'b1;
      end else if (strobe.drvWord0) begin
        memD[8*b +: 8] <= holdW0[8*b +: 8];
        memBwN[b]      <= !holdM0[b];
      end else if (strobe.drvWord1) begin
        memD[8*b +: 8] <= holdW1[8*b +: 8];
        memBwN[b]      <= !holdM1[b];
      end else begin
        memBwN[b]      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData0 <= '0;
      rspData1 <= '0;
    end else begin
      rspValid <= strobe.cap1;
      if (strobe.cap0) rspData0 <= memQ;
      if (strobe.cap1) rspData1 <= memQ;
    end
  end
endmodule

// File: rtl/sio_burst2_ctrl.sv
module sio_burst2_ctrl
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int READ_LAT = 4
) (
  input  logic                clk2x,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata0,
  input  logic [DATA_W-1:0]   reqWdata1,
  input  logic [DATA_W/8-1:0] reqMask0,
  input  logic [DATA_W/8-1:0] reqMask1,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData0,
  output logic [DATA_W-1:0]   rspData1,
  output logic                memClkK,
  output logic                memLoadN,
  output logic                memRw,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memD,
  output logic [DATA_W/8-1:0] memBwN,
  input  logic [DATA_W-1:0]   memQ
);
  ctlStrobe_t strobe;

  sio_b2_ctrl #(.READ_LAT(READ_LAT)) i_ctrl (
    .clk2x    (clk2x),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .kPhase   (memClkK),
    .strobe   (strobe)
  );

  sio_b2_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk2x     (clk2x),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWdata0 (reqWdata0),
    .reqWdata1 (reqWdata1),
    .reqMask0  (reqMask0),
    .reqMask1  (reqMask1),
    .memQ      (memQ),
    .memLoadN  (memLoadN),
    .memRw     (memRw),
    .memAddr   (memAddr),
    .memD      (memD),
    .memBwN    (memBwN),
    .rspValid  (rspValid),
    .rspData0  (rspData0),
    .rspData1  (rspData1)
  );
endmodule

// File: rtl/sio_burst2_ctrl_chk.sv
module sio_burst2_ctrl_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int READ_LAT = 4
) (
  input logic                clk2x,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic                reqWrite,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [DATA_W-1:0]   reqWdata0,
  input logic [DATA_W-1:0]   reqWdata1,
  input logic [DATA_W/8-1:0] reqMask0,
  input logic [DATA_W/8-1:0] reqMask1,
  input logic                rspValid,
  input logic [DATA_W-1:0]   rspData0,
  input logic [DATA_W-1:0]   rspData1,
  input logic                memClkK,
  input logic                memLoadN,
  input logic                memRw,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [DATA_W-1:0]   memD,
  input logic [DATA_W/8-1:0] memBwN,
  input logic [DATA_W-1:0]   memQ
);
  logic acc;
  assign acc = reqValid && reqReady;

  a_r1_load_in_k_slot: assert property (@(posedge clk2x) disable iff (!rstN)
    !memLoadN |-> memClkK);

  a_r1_idle_load_high: assert property (@(posedge clk2x) disable iff (!rstN)
    !acc |=> memLoadN);

  a_r2_r3_command: assert property (@(posedge clk2x) disable iff (!rstN)
    acc |=> (!memLoadN && memRw == !$past(reqWrite) && memAddr == $past(reqAddr)));

  a_r4_word0_slot: assert property (@(posedge clk2x) disable iff (!rstN)
    (acc && reqWrite) |-> ##3
      (memD == $past(reqWdata0, 3) && memBwN == ~$past(reqMask0, 3)));

  a_r4_word1_slot: assert property (@(posedge clk2x) disable iff (!rstN)
    (acc && reqWrite) |-> ##4
      (memD == $past(reqWdata1, 4) && memBwN == ~$past(reqMask1, 4)));

  a_r6_write_gap: assert property (@(posedge clk2x) disable iff (!rstN)
    (acc && reqWrite) |=> !reqReady ##1 !reqReady ##1 !reqReady);

  a_r7_single_pulse: assert property (@(posedge clk2x) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

bind sio_burst2_ctrl sio_burst2_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT)
) i_chk (.*);

// File: tb/test_sio_burst2_ctrl.sv
`timescale 1ns/1ps
module test_sio_burst2_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = DW / 8;
  localparam int RL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata0 = '0, reqWdata1 = '0;
  logic [NB-1:0] reqMask0 = '0, reqMask1 = '0;
  logic          reqReady, rspValid, memClkK, memLoadN, memRw;
  logic [DW-1:0] rspData0, rspData1, memD;
  logic [DW-1:0] memQ = 'z;
  logic [AW-1:0] memAddr;
  logic [NB-1:0] memBwN;

  sio_burst2_ctrl #(.ADDR_W(AW), .DATA_W(DW), .READ_LAT(RL)) i_sio_burst2_ctrl (
    .clk2x(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata0(reqWdata0),
    .reqWdata1(reqWdata1), .reqMask0(reqMask0), .reqMask1(reqMask1),
    .rspValid(rspValid), .rspData0(rspData0), .rspData1(rspData1),
    .memClkK(memClkK), .memLoadN(memLoadN), .memRw(memRw), .memAddr(memAddr),
    .memD(memD), .memBwN(memBwN), .memQ(memQ)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int slotIdx = 0;
  bit noiseMode = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // golden contents from the requirements, and the pin-level memory
  logic [DW-1:0] gold0 [256], gold1 [256], mem0 [256], mem1 [256];
  initial for (int i = 0; i < 256; i++) begin
    gold0[i] = '0; gold1[i] = '0; mem0[i] = '0; mem1[i] = '0;
  end

  // per-slot command history (mod 16)
  bit            hWr [16], hRd [16];
  logic [AW-1:0] hAddr [16];
  logic [DW-1:0] hSnap0 [16], hSnap1 [16];
  initial for (int i = 0; i < 16; i++) begin hWr[i] = 0; hRd[i] = 0; end

  always @(posedge clk) slotIdx <= slotIdx + 1;

  // behavioural memory, acting mid-slot
  always @(negedge clk) if (rstN) begin
    automatic int t = slotIdx;
    automatic int i2 = (t - 2) & 15;
    automatic int i3 = (t - 3) & 15;
    automatic int iq0 = (t - RL) & 15;
    automatic int iq1 = (t - RL - 1) & 15;
    automatic bit wr0 = (t >= 2) && hWr[i2];
    automatic bit wr1 = (t >= 3) && hWr[i3];
    // memory drive of Q for this slot
    if (t >= RL && hRd[iq0]) memQ = hSnap0[iq0];
    else if (t >= RL + 1 && hRd[iq1]) memQ = hSnap1[iq1];
    else memQ = noiseMode ? 16'hDEAD : 'z;
    // R4: byte enables active only in the two write data slots
    if (wr0) begin
      for (int b = 0; b < NB; b++)
        if (!memBwN[b]) mem0[hAddr[i2]][8*b +: 8] = memD[8*b +: 8];
      chk(memClkK == 1'b1, "R4 word0 in primary slot", memClkK, 1);
    end else if (wr1) begin
      for (int b = 0; b < NB; b++)
        if (!memBwN[b]) mem1[hAddr[i3]][8*b +: 8] = memD[8*b +: 8];
      chk(memClkK == 1'b0, "R4 word1 in inverted slot", memClkK, 0);
    end else if (memBwN != '1) begin
      chk(0, "R4 stray byte enable", memBwN, {NB{1'b1}});
    end
    // record this slot's command
    hWr[t & 15] = 0; hRd[t & 15] = 0;
    if (!memLoadN) begin
      chk(memClkK == 1'b1, "R1 load only in primary slot", memClkK, 1);
      hAddr[t & 15] = memAddr;
      if (memRw) begin
        hRd[t & 15] = 1;
        hSnap0[t & 15] = mem0[memAddr];
        hSnap1[t & 15] = mem1[memAddr];
      end else hWr[t & 15] = 1;
    end
  end

  // expected read responses
  logic [DW-1:0] exp0 [64], exp1 [64];
  int expSlot [64];
  int expHead = 0, expTail = 0;

  always @(negedge clk) if (rstN && rspValid) begin
    if (expHead == expTail) chk(0, "R7 unexpected response", 1, 0);
    else begin
      chk(rspData0 == exp0[expHead], "R8 word0 order/data", rspData0, exp0[expHead]);
      chk(rspData1 == exp1[expHead], "R8 word1 order/data", rspData1, exp1[expHead]);
      chk(slotIdx == expSlot[expHead], "R7 response slot", slotIdx, expSlot[expHead]);
      expHead++;
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] w0,
                       input logic [DW-1:0] w1, input logic [NB-1:0] m0,
                       input logic [NB-1:0] m1, output int slot);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a;
    reqWdata0 = w0; reqWdata1 = w1; reqMask0 = m0; reqMask1 = m1;
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    slot = slotIdx;
    reqValid = 0;
  endtask

  task automatic goldWrite(input logic [AW-1:0] a, input logic [DW-1:0] w0,
                           input logic [DW-1:0] w1, input logic [NB-1:0] m0,
                           input logic [NB-1:0] m1);
    for (int b = 0; b < NB; b++) begin
      if (m0[b]) gold0[a][8*b +: 8] = w0[8*b +: 8];
      if (m1[b]) gold1[a][8*b +: 8] = w1[8*b +: 8];
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] w0,
                         input logic [DW-1:0] w1, input logic [NB-1:0] m0,
                         input logic [NB-1:0] m1);
    int s;
    issue(1, a, w0, w1, m0, m1, s);
    goldWrite(a, w0, w1, m0, m1);
    @(negedge clk);
    chk(!memLoadN && !memRw && memAddr == a, "R3 write command", {memLoadN, memRw, memAddr}, {2'b00, a});
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    int s;
    issue(0, a, '0, '0, '0, '0, s);
    exp0[expTail] = gold0[a]; exp1[expTail] = gold1[a];
    expSlot[expTail] = s + RL + 2;
    expTail++;
    @(negedge clk);
    chk(!memLoadN && memRw && memAddr == a, "R2 read command", {memLoadN, memRw, memAddr}, {2'b01, a});
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && expHead != expTail; i++) @(negedge clk);
    chk(expHead == expTail, "R7 all responses returned", expTail - expHead, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    chk(memLoadN == 1'b1, "R1 load idle after reset", memLoadN, 1);
    chk(memBwN == '1, "R1 byte enables idle", memBwN, {NB{1'b1}});
    chk(rspValid == 1'b0, "R1 no response after reset", rspValid, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(reqReady == !memClkK, "R6 ready only before primary slot", reqReady, !memClkK);
    end
  endtask

  task automatic tFullBurst;
    doWrite(8'h11, 16'hA1B2, 16'hC3D4, 2'b11, 2'b11);
    doRead(8'h11);
    drain();
  endtask

  task automatic tByteMask;
    doWrite(8'h22, 16'h1111, 16'h2222, 2'b11, 2'b11);
    doWrite(8'h22, 16'hAAAA, 16'hBBBB, 2'b01, 2'b10);
    doRead(8'h22);
    drain();
    chk(gold0[8'h22] == 16'h11AA && gold1[8'h22] == 16'hBB22, "R5 bench lane model",
        {gold0[8'h22], gold1[8'h22]}, 32'h11AABB22);
  endtask

  task automatic tWordSuppress;
    doWrite(8'h33, 16'h5555, 16'h6666, 2'b11, 2'b11);
    doWrite(8'h33, 16'h7777, 16'h8888, 2'b00, 2'b11);
    doWrite(8'h34, 16'h9999, 16'hEEEE, 2'b11, 2'b00);
    doRead(8'h33);
    doRead(8'h34);
    drain();
  endtask

  task automatic tWriteGap;
    int s;
    issue(1, 8'h44, 16'h0F0F, 16'hF0F0, 2'b11, 2'b11, s);
    goldWrite(8'h44, 16'h0F0F, 16'hF0F0, 2'b11, 2'b11);
    reqValid = 1; reqWrite = 0; reqAddr = 8'h44;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(reqReady == 1'b0, "R6 no command during write data", reqReady, 0);
    end
    @(negedge clk);
    chk(reqReady == 1'b1, "R6 ready after second word", reqReady, 1);
    reqValid = 0;
    doRead(8'h44);
    drain();
  endtask

  task automatic tBackToBack;
    doWrite(8'h50, 16'h0101, 16'h0202, 2'b11, 2'b11);
    doWrite(8'h51, 16'h0303, 16'h0404, 2'b11, 2'b11);
    doWrite(8'h52, 16'h0505, 16'h0606, 2'b11, 2'b11);
    doRead(8'h50);
    doRead(8'h51);
    doRead(8'h52);
    doRead(8'h50);
    drain();
  endtask

  task automatic tQNoise;
    noiseMode = 1;
    doWrite(8'h60, 16'h1234, 16'h5678, 2'b11, 2'b11);
    doRead(8'h60);
    drain();
    chk(rspData0 == 16'h1234 && rspData1 == 16'h5678, "R7 Q ignored outside capture",
        {rspData0, rspData1}, 32'h12345678);
    noiseMode = 0;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tFullBurst();
    tByteMask();
    tWordSuppress();
    tWriteGap();
    tBackToBack();
    tQNoise();
    finishRun();
  end
endmodule